// File: doc/BRIEF.md
# Strobed serial command decoder

This block is the host-facing serial port of a display controller. A host frames each transaction with an active-low strobe. While the strobe is low, the host clocks bytes in least significant bit first, sampled on rising edges of the serial clock. The first byte of a frame is a command. Its top two bits pick one of four classes: display mode, data setting, display control or address setting. The bytes that follow are handled according to the operation chosen by the last data-setting command:

- display memory writes, with an optional address increment;
- writes to the active-low LED port;
- key readout bytes;
- switch readout bytes.

Read data leaves on an open-drain line, which the block models as a pull-low enable. New bits appear after falling edges of the serial clock.

The serial lines are asynchronous to the block. They pass through two-flop synchronizers, and edges are detected on a faster system clock. The block holds the display mode, dimming code, display-on flag, LED drive bits, test flag, transfer operation, increment mode and display address. It issues one-cycle display memory write strobes. For reads, it presents a byte index and a source select to the key/switch readout and takes back the addressed byte.

Top module: `strobe_cmd_decoder`

## Requirements
- R1: After reset the display mode is 3'b111, the dimming code is 0, the display is off, all four LED drive bits are 1 (off), the test flag is 0, the operation is display write with increment, the address is 0 and the open-drain output is released.
- R2: Bits arrive least significant first, taken on serial clock rising edges. In the first byte of a frame, bits 7:6 select the class: 00 display mode, 01 data setting, 10 display control, 11 address setting.
- R3: A display control command loads the dimming code from bits 2:0 and the display-on flag from bit 3.
- R4: A display mode command loads the mode from bits 2:0 and ignores bits 5:3. If the new mode differs from the held one, the display is switched off. If it is equal, the display flag keeps its value.
- R5: With operation 00 (bits 1:0 of the data-setting command) and bit 2 clear, each completed data byte gives one write strobe at the current address with that byte, and the address then advances by one.
- R6: With bit 2 of the data-setting command set, every data byte is written to the same address.
- R7: An address command loads a 5-bit address from bits 4:0. Addresses 0x00 to 0x15 are writable. At 0x16 and above, data bytes produce no write. In increment mode a write at 0x15 is followed by no further writes.
- R8: With operation 01, bits 3:0 of each data byte load the LED drive bits (0 = lit), and bits 7:4 have no effect. No display write occurs.
- R9: While the strobe is high the serial clock has no effect. A strobe rise in the middle of a byte discards it, and the next frame starts at bit 0 of a new command.
- R10: After a data-setting command with operation 10 in the same frame, each following byte is read out. Before the first falling edge of a byte, the readout byte at the current index is captured. On each falling edge bit k (LSB first) is presented, with the output pulled low for a 0 bit. The index starts at 0 and advances after each byte, wrapping after three bytes.
- R11: Operation 11 reads switch data the same way, with the select output at 1; for key reads it is 0.
- R12: Bit 3 of the data-setting command sets the test flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_stb | input | 1 | Frame strobe, active low |
| ser_clk | input | 1 | Serial clock, idles high |
| ser_din | input | 1 | Serial data in |
| ser_dout_low | output | 1 | Open-drain pull-low enable for serial data out |
| ram_we | output | 1 | One-cycle display memory write strobe |
| ram_addr | output | 5 | Display memory write address |
| ram_wdata | output | 8 | Display memory write byte |
| rd_sel | output | 1 | Readout source: 0 keys, 1 switches |
| rd_idx | output | 2 | Readout byte index |
| rd_data | input | 8 | Readout byte at rd_sel/rd_idx |
| disp_mode | output | 3 | Held display mode code |
| dim_code | output | 3 | Held dimming code |
| disp_on | output | 1 | Display-on flag |
| led_n | output | 4 | LED drive bits, 0 = lit |
| test_mode | output | 1 | Test flag |

## Verification
The embedded properties assume the following about the serial inputs:

- each serial clock phase lasts several system clock cycles, so that consecutive data bytes are far apart and a write strobe is never followed directly by another;
- data is stable around rising edges;
- the strobe stays high between frames long enough for the synchronizers to settle.

The stimulus holds each serial clock phase for eight system cycles and changes data only with the falling edge. It waits between the command byte and the first read byte, and raises the strobe only after the last edge of a frame, except in the deliberate mid-byte abort.

// File: rtl/strobe_cmd_decoder.sv
module strobe_cmd_decoder #(
  parameter int ADDR_W    = 5,
  parameter int LAST_ADDR = 21,
  parameter int KEY_BYTES = 3,
  parameter int IDX_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_stb,
  input  logic              ser_clk,
  input  logic              ser_din,
  output logic              ser_dout_low,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              rd_sel,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [7:0]        rd_data,
  output logic [2:0]        disp_mode,
  output logic [2:0]        dim_code,
  output logic              disp_on,
  output logic [3:0]        led_n,
  output logic              test_mode
);
  localparam logic [ADDR_W-1:0] ADDR_MAX = ADDR_W'(LAST_ADDR);
  localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(KEY_BYTES - 1);

  logic [2:0] stb_q, clk_q;
  logic [1:0] din_q;
  logic [6:0] sh;
  logic [2:0] bitcnt;
  logic       first, rd_phase, txbit, fixed;
  logic [7:0] txsh;
  logic [1:0] op;
  logic [ADDR_W-1:0] addr;

  wire stb_s     = stb_q[1];
  wire din_s     = din_q[1];
  wire sclk_rise = clk_q[1] & ~clk_q[2] & ~stb_s;
  wire sclk_fall = ~clk_q[1] & clk_q[2] & ~stb_s;
  wire [7:0] byte_val = {din_s, sh};
  wire byte_done = sclk_rise && (bitcnt == 3'd7);
  wire addr_ok   = addr <= ADDR_MAX;

  assign ser_dout_low = rd_phase & ~txbit;
  assign rd_sel       = op[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 3'b111;
      clk_q <= 3'b111;
      din_q <= 2'b00;
    end else begin
      stb_q <= {stb_q[1:0], ser_stb};
      clk_q <= {clk_q[1:0], ser_clk};
      din_q <= {din_q[0], ser_din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; bitcnt <= '0; first <= 1'b1; rd_phase <= 1'b0;
      txbit <= 1'b1; txsh <= '0; op <= '0; fixed <= 1'b0;
      addr <= '0; ram_we <= 1'b0; ram_addr <= '0; ram_wdata <= '0;
      rd_idx <= '0; disp_mode <= 3'b111; dim_code <= '0;
      disp_on <= 1'b0; led_n <= 4'hF; test_mode <= 1'b0;
    end else begin
      ram_we <= 1'b0;
      if (stb_s) begin
        bitcnt <= '0; first <= 1'b1; rd_phase <= 1'b0; txbit <= 1'b1;
      end else begin
        if (sclk_rise) begin
          sh     <= byte_val[7:1];
          bitcnt <= bitcnt + 3'd1;
        end
        if (byte_done) begin
          first <= 1'b0;
          if (first) begin
            case (byte_val[7:6])
              2'b00: begin
                disp_mode <= byte_val[2:0];
                if (byte_val[2:0] != disp_mode) disp_on <= 1'b0;
              end
              2'b01: begin
                op <= byte_val[1:0]; fixed <= byte_val[2];
                test_mode <= byte_val[3]; rd_phase <= byte_val[1];
                rd_idx <= '0;
              end
              2'b10: begin
                dim_code <= byte_val[2:0]; disp_on <= byte_val[3];
              end
              default: addr <= byte_val[ADDR_W-1:0];
            endcase
          end else if (rd_phase) begin
            rd_idx <= (rd_idx == IDX_LAST) ? '0 : rd_idx + IDX_W'(1);
          end else if (!op[1]) begin
            if (op[0]) led_n <= byte_val[3:0];
            else if (addr_ok) begin
              ram_we <= 1'b1; ram_addr <= addr; ram_wdata <= byte_val;
              if (!fixed) addr <= addr + ADDR_W'(1);
            end
          end
        end
        if (sclk_fall && rd_phase) begin
          if (bitcnt == 3'd0) begin
            txsh <= rd_data; txbit <= rd_data[0];
          end else begin
            txbit <= txsh[bitcnt];
          end
        end
      end
    end
  end

  // R5
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |=> !ram_we);
  // R7
  we_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_addr <= ADDR_MAX));
  // R4
  mode_change_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(disp_mode) |-> !disp_on);
  // R8
  led_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_n) |-> $past(byte_done));
  // R10
  dout_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_dout_low |-> !$past(stb_s));
endmodule

// File: tb/strobe_cmd_decoder_tb.sv
`timescale 1ns/1ps
module strobe_cmd_decoder_tb_top;
  logic clk = 0, rst_n = 0;
  logic stb = 1, sclk = 1, din = 0;
  logic dout_low, ram_we, rd_sel, disp_on, test_mode;
  logic [4:0] ram_addr;
  logic [7:0] ram_wdata, rd_data;
  logic [1:0] rd_idx;
  logic [2:0] disp_mode, dim_code;
  logic [3:0] led_n;
  logic [3:0] sw = 4'hA;
  int total = 0, bad = 0, wc = 0;
  logic [4:0] wa [0:63];
  logic [7:0] wd [0:63];

  always #10 clk = ~clk;

  assign rd_data = rd_sel ? {4'b0, sw} : (8'(rd_idx) * 8'h4B + 8'h1C);

  strobe_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ser_stb(stb), .ser_clk(sclk), .ser_din(din),
    .ser_dout_low(dout_low), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .rd_sel(rd_sel), .rd_idx(rd_idx),
    .rd_data(rd_data), .disp_mode(disp_mode), .dim_code(dim_code),
    .disp_on(disp_on), .led_n(led_n), .test_mode(test_mode));

  always @(posedge clk) if (rst_n && ram_we && wc < 64) begin
    wa[wc] <= ram_addr; wd[wc] <= ram_wdata; wc <= wc + 1;
  end

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic open_f; stb = 0; tick(8); endtask
  task automatic close_f; tick(8); stb = 1; tick(10); endtask

  task automatic send_byte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 0; din = b[i]; tick(8); sclk = 1; tick(8);
    end
  endtask

  task automatic read_byte(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      sclk = 0; tick(8); b[i] = !dout_low; sclk = 1; tick(8);
    end
  endtask

  task automatic cmd(logic [7:0] c); open_f; send_byte(c); close_f; endtask

  initial begin
    #3_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rb, v;
    int base;
    logic [2:0] prev;
    tick(5); rst_n = 1; tick(5);
    // R1 reset state
    chk("R1 mode", disp_mode, 7); chk("R1 dim", dim_code, 0);
    chk("R1 on", disp_on, 0); chk("R1 led", led_n, 4'hF);
    chk("R1 test", test_mode, 0); chk("R1 dout", dout_low, 0);
    chk("R1 idx", rd_idx, 0);
    // R2: LSB-first and class select
    cmd(8'h8E); chk("R2 dim", dim_code, 6); chk("R2 on", disp_on, 1);
    cmd(8'h01); chk("R2 mode", disp_mode, 1); chk("R2 dim kept", dim_code, 6);
    // R3 exhaustive control sweep
    for (int c = 0; c < 16; c++) begin
      cmd(8'h80 | 8'(c));
      chk("R3 dim", dim_code, c & 7); chk("R3 on", disp_on, c >> 3);
    end
    // R4 mode sweep
    prev = disp_mode;
    for (int m = 0; m < 8; m++) begin
      cmd(8'h8F);
      cmd(8'(m) | 8'((m * 5) & 7) << 3);
      chk("R4 mode", disp_mode, m); chk("R4 on", disp_on, (m == prev) ? 1 : 0);
      prev = 3'(m);
      cmd(8'h8F); cmd(8'(m) | 8'h38);
      chk("R4 same on", disp_on, 1);
    end
    // R5 increment across whole range, R7 stop past 0x15
    cmd(8'h40); base = wc;
    open_f; send_byte(8'hC0);
    for (int k = 0; k < 23; k++) send_byte(8'h5A ^ 8'(k * 7));
    close_f;
    chk("R7 count", wc - base, 22);
    for (int k = 0; k < 22; k++) begin
      chk("R5 addr", wa[base + k], k); chk("R5 data", wd[base + k], 8'h5A ^ 8'(k * 7));
    end
    // R7 invalid addresses
    base = wc;
    open_f; send_byte(8'hD6); send_byte(8'h11); send_byte(8'h22); close_f;
    open_f; send_byte(8'hDF); send_byte(8'h33); close_f;
    chk("R7 invalid", wc - base, 0);
    open_f; send_byte(8'hD5); send_byte(8'h77); send_byte(8'h88); close_f;
    chk("R7 last cnt", wc - base, 1);
    chk("R7 last addr", wa[base], 21); chk("R7 last data", wd[base], 8'h77);
    // R6 fixed address
    cmd(8'h44); base = wc;
    open_f; send_byte(8'hC3); send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); close_f;
    chk("R6 count", wc - base, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R6 addr", wa[base + k], 3); chk("R6 data", wd[base + k], k + 1);
    end
    // R8 LED sweep
    base = wc;
    for (int i = 0; i < 16; i++) begin
      v = {~4'(i), 4'(i)};
      open_f; send_byte(8'h41); send_byte(v); close_f;
      chk("R8 led", led_n, i);
    end
    chk("R8 no ram", wc - base, 0);
    // R9 abort and ignored clock
    cmd(8'h8A);
    open_f;
    for (int i = 0; i < 4; i++) begin
      sclk = 0; din = (i % 2 == 0); tick(8); sclk = 1; tick(8);
    end
    stb = 1; tick(10);
    chk("R9 dim kept", dim_code, 2); chk("R9 on kept", disp_on, 1);
    for (int i = 0; i < 8; i++) begin
      sclk = 0; din = 1; tick(8); sclk = 1; tick(8);
    end
    chk("R9 ignored", dim_code, 2);
    cmd(8'h80); chk("R9 realign dim", dim_code, 0); chk("R9 realign on", disp_on, 0);
    // R12 test flag
    cmd(8'h48); chk("R12 set", test_mode, 1);
    cmd(8'h40); chk("R12 clear", test_mode, 0);
    // R10 key readout with wrap
    open_f; send_byte(8'h42); tick(30);
    chk("R10 released", dout_low, 0); chk("R11 key sel", rd_sel, 0);
    for (int k = 0; k < 4; k++) begin
      read_byte(rb);
      chk("R10 key byte", rb, 8'((k % 3) * 8'h4B + 8'h1C));
    end
    close_f; chk("R10 end released", dout_low, 0);
    // R11 switch readout
    sw = 4'hA;
    open_f; send_byte(8'h43); tick(30);
    chk("R11 sw sel", rd_sel, 1);
    read_byte(rb); chk("R11 sw", rb, 8'h0A);
    sw = 4'h5; read_byte(rb); chk("R11 sw2", rb, 8'h05);
    close_f;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule